// File: doc/BRIEF.md
# Grouped Two-Line Interrupt Router

This block collects event pulses from a CAN FD style controller core and turns them into two interrupt request lines. Each of the 24 sources has a sticky pending flag, set by a one-cycle pulse from the core. A pending flag raises an interrupt only when that source is enabled. Each source is steered to line 0 or line 1, and each line is gated by its own line-enable bit.

In the default build, the sources are sorted into seven category groups. One steering bit per group moves all of that group's sources to the same line together. A build parameter selects an ungrouped variant instead, with one steering bit per source.

Software reaches four registers through a small synchronous write port with a combinational read mux. Pending flags are cleared by writing 1 to them.

Top module: `evt_line_router`

## Requirements
- R1: After reset, both interrupt lines are low and all four registers read as zero. Address 0 holds the pending flags, address 1 the source enables, address 2 the line steering and address 3 the line enables.
- R2: A pulse on source input bit i sets pending flag bit i at address 0. The flag stays set until it is cleared, whether or not the source is enabled. Bit i carries these sources:
  - bits 0-2: receive queue A new, full, lost
  - bits 3-5: receive queue B new, full, lost
  - bit 6: priority message
  - bit 7: transmit done
  - bit 8: cancel done
  - bit 9: transmit queue empty
  - bits 10-12: transmit event queue new, full, lost
  - bit 13: timestamp wrap
  - bit 14: RAM access fault
  - bit 15: timeout
  - bit 16: error log overflow
  - bit 17: error passive
  - bit 18: warning
  - bit 19: bus-off
  - bit 20: watchdog
  - bit 21: arbitration protocol error
  - bit 22: data protocol error
  - bit 23: reserved address access
- R3: Writing to address 0 clears every flag whose data bit is 1 and leaves flags with a data bit of 0 unchanged. A pulse and a clear on the same bit in the same cycle leave the flag set.
- R4: A pending source drives a line only while its enable bit (address 1, bit i) is 1. The steering bits alone never raise a line.
- R5: In the grouped build, address 2 bit g steers group g: 0 selects line 0 and 1 selects line 1. The groups are:
  - bit 0: sources 0-2
  - bit 1: sources 3-5
  - bit 2: sources 6-8
  - bit 3: sources 9-12
  - bit 4: sources 13-15
  - bit 5: sources 16-17
  - bit 6: sources 18-23
- R6: Line 0 can be high only while address 3 bit 0 is 1. Line 1 can be high only while address 3 bit 1 is 1.
- R7: Each line is a register. It equals the OR over all sources of (flag AND enable AND steered to that line), ANDed with the line enable, as those values stood one clock earlier.
- R8: Enabling a source whose flag is already pending raises its line on the clock after the enable write.
- R9: Bits above the implemented width read as zero, and writes to them are ignored. The widths are 24 for flags and enables, 7 for grouped steering (24 when ungrouped), and 2 for line enables.
- R10: With GROUPED=0, address 2 bit i steers source i alone to line 1 when set and to line 0 when clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 24 | One-cycle event pulses from the controller core |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Read data for the register at addr |
| irqLine | output | 2 | Interrupt lines; bit 0 is line 0, bit 1 is line 1 |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a new pulse on the same source, combined with a pending flag whose enable or steering changes while the flag is held. Random traffic rarely lines these up.

Directed steps therefore fire a pulse and a write-1 clear together, and raise a flag before its source is enabled. A shadow model then carries long random runs of sparse pulses, clears, enable flips and steering rewrites.

Two instances, one grouped and one ungrouped, take identical stimulus. The same steering word must then route differently on each.

// File: rtl/evt_line_pkg.sv
package evt_line_pkg;

  typedef enum logic [1:0] {
    REG_FLAGS  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_SELECT = 2'd2,
    REG_LINEEN = 2'd3
  } regAddr_t;

  typedef struct packed {
    logic clrFlags;
    logic wrEnable;
    logic wrSelect;
    logic wrLineEn;
  } regStrobe_t;

  // Category group that owns a source in the grouped build.
  function automatic int unsigned groupOf(input int unsigned src);
    if (src < 3)       return 0;
    else if (src < 6)  return 1;
    else if (src < 9)  return 2;
    else if (src < 13) return 3;
    else if (src < 16) return 4;
    else if (src < 18) return 5;
    else               return 6;
  endfunction

endpackage

// File: rtl/evt_line_ctrl.sv
module evt_line_ctrl
  import evt_line_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe,
  output regAddr_t          rdSel
);
  logic inRange;
  regAddr_t low;

  generate
    if (ADDR_W > 2) begin : g_wide
      assign inRange = (addr[ADDR_W-1:2] == '0);
    end else begin : g_narrow
      assign inRange = 1'b1;
    end
  endgenerate

  assign low   = regAddr_t'(addr[1:0]);
  assign rdSel = low;

  always_comb begin
    strobe = '0;
    if (wrEn && inRange) begin
      case (low)
        REG_FLAGS:  strobe.clrFlags = 1'b1;
        REG_ENABLE: strobe.wrEnable = 1'b1;
        REG_SELECT: strobe.wrSelect = 1'b1;
        REG_LINEEN: strobe.wrLineEn = 1'b1;
        default:    strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_line_dp.sv
module evt_line_dp
  import evt_line_pkg::*;
#(
  parameter int SRC_N   = 24,
  parameter int GRP_N   = 7,
  parameter int DATA_W  = 32,
  parameter bit GROUPED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  evtPulse,
  input  regStrobe_t        strobe,
  input  regAddr_t          rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        irqLine
);
  localparam int SEL_W  = GROUPED ? GRP_N : SRC_N;
  localparam int LINE_N = 2;

  logic [SRC_N-1:0]  flagsQ, enQ, routeHi, live;
  logic [SEL_W-1:0]  selQ;
  logic [LINE_N-1:0] lineEnQ, irqQ;
  logic [SRC_N-1:0]  clrMask;
  logic              hit0, hit1;

  assign clrMask = strobe.clrFlags ? wrData[SRC_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ  <= '0;
      enQ     <= '0;
      selQ    <= '0;
      lineEnQ <= '0;
      irqQ    <= '0;
    end else begin
      flagsQ <= (flagsQ & ~clrMask) | evtPulse;
      if (strobe.wrEnable) enQ     <= wrData[SRC_N-1:0];
      if (strobe.wrSelect) selQ    <= wrData[SEL_W-1:0];
      if (strobe.wrLineEn) lineEnQ <= wrData[LINE_N-1:0];
      irqQ <= {lineEnQ[1] & hit1, lineEnQ[0] & hit0};
    end
  end

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_route
      if (GROUPED) begin : g_grp
        localparam int G = groupOf(i);
        assign routeHi[i] = selQ[G];
      end else begin : g_flat
        assign routeHi[i] = selQ[i];
      end
    end
  endgenerate

  assign live = flagsQ & enQ;
  assign hit0 = |(live & ~routeHi);
  assign hit1 = |(live & routeHi);
  assign irqLine = irqQ;

  always_comb begin
    rdData = '0;
    case (rdSel)
      REG_FLAGS:  rdData[SRC_N-1:0]  = flagsQ;
      REG_ENABLE: rdData[SRC_N-1:0]  = enQ;
      REG_SELECT: rdData[SEL_W-1:0]  = selQ;
      REG_LINEEN: rdData[LINE_N-1:0] = lineEnQ;
      default:    rdData = '0;
    endcase
  end

  // R2: without a clear strobe no pending flag drops
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrFlags |=> ((flagsQ & $past(flagsQ)) == $past(flagsQ)));

  // R3: a pulse always lands, even against a clear
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((flagsQ & $past(evtPulse)) == $past(evtPulse)));

  // R4: nothing enabled means both lines low next cycle
  assert_no_enable_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |=> (irqLine == 2'b00));

  // R6: each line gated by its own enable bit
  assert_line0_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnQ[0] |=> !irqLine[0]);
  assert_line1_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnQ[1] |=> !irqLine[1]);
endmodule

// File: rtl/evt_line_router.sv
module evt_line_router
  import evt_line_pkg::*;
#(
  parameter int SRC_N   = 24,
  parameter int GRP_N   = 7,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter bit GROUPED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  evtPulse,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        irqLine
);
  regStrobe_t strobe;
  regAddr_t   rdSel;

  evt_line_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  evt_line_dp #(
    .SRC_N(SRC_N), .GRP_N(GRP_N), .DATA_W(DATA_W), .GROUPED(GROUPED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .evtPulse (evtPulse),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .wrData   (wrData),
    .rdData   (rdData),
    .irqLine  (irqLine)
  );
endmodule

// File: tb/evt_line_router_tb.sv
module evt_line_router_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] evtPulse = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdG, rdF;
  logic [1:0]  irqG, irqF;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [23:0] mFlags = '0, mEn = '0, mSelF = '0;
  logic [6:0]  mSelG = '0;
  logic [1:0]  mLine = '0;

  always #10 clk = ~clk;

  evt_line_router u_dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdG), .irqLine(irqG));

  evt_line_router #(.GROUPED(1'b0)) u_flat (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdF), .irqLine(irqF));

  function automatic int grpOf(input int s);
    if (s < 3) return 0; else if (s < 6) return 1; else if (s < 9) return 2;
    else if (s < 13) return 3; else if (s < 16) return 4; else if (s < 18) return 5;
    return 6;
  endfunction

  function automatic logic [1:0] expIrq(input bit flat);
    logic h0 = 1'b0, h1 = 1'b0;
    for (int i = 0; i < 24; i++) begin
      logic r;
      r = flat ? mSelF[i] : mSelG[grpOf(i)];
      if (mFlags[i] && mEn[i]) begin
        if (r) h1 = 1'b1; else h0 = 1'b1;
      end
    end
    return {mLine[1] & h1, mLine[0] & h0};
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] a, input bit flat);
    case (a)
      2'd0: return {8'h0, mFlags};
      2'd1: return {8'h0, mEn};
      2'd2: return flat ? {8'h0, mSelF} : {25'h0, mSelG};
      default: return {30'h0, mLine};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] evt, input logic we, input logic [1:0] a,
                      input logic [31:0] wd, input string tag);
    logic [1:0] eG, eF;
    evtPulse = evt; wrEn = we; addr = a; wrData = wd;
    @(posedge clk);
    eG = expIrq(1'b0);
    eF = expIrq(1'b1);
    if (we && a == 2'd0) mFlags = mFlags & ~wd[23:0];
    mFlags = mFlags | evt;
    if (we && a == 2'd1) mEn = wd[23:0];
    if (we && a == 2'd2) begin mSelG = wd[6:0]; mSelF = wd[23:0]; end
    if (we && a == 2'd3) mLine = wd[1:0];
    #1;
    check({tag, " irq grouped"}, {30'h0, irqG}, {30'h0, eG});
    check({tag, " irq flat"},    {30'h0, irqF}, {30'h0, eF});
    check({tag, " read grouped"}, rdG, expRead(a, 1'b0));
    check({tag, " read flat"},    rdF, expRead(a, 1'b1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state on every register and line
    for (int a = 0; a < 4; a++) step('0, 1'b0, a[1:0], '0, "R1");
    // R2: flag latches while source disabled; R4: no line
    step(24'h000020, 1'b0, 2'd0, '0, "R2");
    step('0, 1'b1, 2'd3, 32'h3, "R4");
    step('0, 1'b0, 2'd0, '0, "R2");
    // R8: enable pending source, line 0 next cycle
    step('0, 1'b1, 2'd1, 32'h20, "R8");
    step('0, 1'b0, 2'd1, '0, "R8");
    // R5: group 1 to line 1 (flat: bit 1 steers source 1 only)
    step('0, 1'b1, 2'd2, 32'h2, "R5");
    step('0, 1'b0, 2'd2, '0, "R5");
    // R6: drop line 0 enable, then line 1 enable
    step('0, 1'b1, 2'd3, 32'h2, "R6");
    step('0, 1'b1, 2'd3, 32'h1, "R6");
    step('0, 1'b1, 2'd3, 32'h3, "R6");
    // R3: clear with zero bits, clear with ones, clear against pulse
    step('0, 1'b1, 2'd0, 32'h0, "R3");
    step(24'h000001, 1'b1, 2'd0, 32'h21, "R3");
    step('0, 1'b1, 2'd0, 32'h1, "R3");
    // R9: all-ones writes read back masked
    step('0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R9");
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFF, "R9");
    step('0, 1'b1, 2'd3, 32'hFFFF_FFFF, "R9");
    step(24'hFFFFFF, 1'b1, 2'd0, 32'hFF00_0000, "R9");
    // R10: same steering word, different routing per build
    step('0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R10");
    step(24'h002018, 1'b1, 2'd2, 32'h10, "R10");
    step('0, 1'b0, 2'd0, '0, "R10");
    step('0, 1'b1, 2'd0, 32'h2000, "R10");
    step('0, 1'b0, 2'd2, '0, "R10");
    // R7: random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] ev;
      logic [31:0] wd;
      ev = ($urandom % 4 == 0) ? (24'h1 << ($urandom % 24)) : '0;
      wd = $urandom;
      if ($urandom % 3 == 0) wd = wd & $urandom;
      step(ev, ($urandom % 3 == 0), 2'($urandom % 4), wd, "R7");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule